// File: doc/BRIEF.md
# Adaptive Dead-Time Gate Sequencer

This block converts one pulse-width command into two gate enables for the high-side and low-side switches of a synchronous step-down power stage. It never switches one device on until it has sensed that the other one is off. A high-side turn-on waits for a comparator flag reporting that the low-side gate voltage has fallen. A low-side turn-on waits for a comparator flag reporting that the switching node has dropped. Both flags come from analog comparators, so each one passes through a synchronizer before the sequencer uses it.

The switching node may never drop when inductor current flows backwards. A timeout therefore starts when the high-side enable goes away, and it switches the low side on anyway so the current can recirculate. Protection logic has two controls. A global enable, when low, holds both gates off, for example during a fault-off interval. A force input makes the low side the only permitted switch, whatever the command says. A confirmation only counts if its flag was sampled after the opposite gate was removed. This keeps a stale flag still in the synchronizer from ending the dead time early.

Top module: `dtg_gate_sequencer`

## Requirements
- R1: While reset is asserted, and after it is released while `enable_i` is low, both `hs_gate_o` and `ls_gate_o` are 0 whatever the command does.
- R2: `hs_gate_o` and `ls_gate_o` are never 1 in the same cycle. Neither output rises in the cycle directly after the other was 1.
- R3: While waiting to turn the low side on, `phase_low_i` (1 = switching node low) confirms the turn-on. The value only counts if it was sampled after the high-side enable fell. A flag that rises during the wait turns `ls_gate_o` on at the third rising edge after it is first sampled. The flag already being high gives the same result, three cycles after `hs_gate_o` falls.
- R4: If `phase_low_i` stays 0, `ls_gate_o` rises exactly `WDOG_CYCLES` cycles after `hs_gate_o` fell.
- R5: The high side turns on only after `ls_gate_low_i` (1 = low-side gate low) is confirmed, with the same sampling and three-edge latency as R3. While the flag stays 0, `hs_gate_o` stays 0.
- R6: If the command (`pwm_i` = 1 requests the high side) returns while the low-side turn-on is still pending, that turn-on is dropped. `ls_gate_o` stays 0, and the high side returns only after low-side-off confirmation.
- R7: `enable_i` sampled 0 turns both gates off at the next edge and keeps them off. When it returns, the sequence restarts through the confirmation states.
- R8: `force_ls_i` sampled 1 removes the high side at the next edge and keeps it off. The low side then turns on through R3 or R4 and stays on whatever `pwm_i` does.
- R9: In steady state a gate stays on for as long as the command that selected it holds.
- R10: From idle, enabling with `pwm_i` high waits for low-side confirmation. `hs_gate_o` rises at the fourth edge when the flag is already settled high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Global enable; 0 holds both gates off |
| pwm_i | input | 1 | Switching command; 1 requests high side, 0 low side |
| force_ls_i | input | 1 | Protection request: low side only |
| phase_low_i | input | 1 | Asynchronous flag: switching node is low |
| ls_gate_low_i | input | 1 | Asynchronous flag: low-side gate voltage is low |
| hs_gate_o | output | 1 | High-side gate enable |
| ls_gate_o | output | 1 | Low-side gate enable |

## Verification
The hardest case to reach is a command that returns in the middle of the low-side wait. The switching-node flag has to stay low the whole time, and the high-side request has to come back before the timeout ends. The stimulus models the power stage, with flags that follow the gates after a random lag. Some random segments model reverse current, where the switching-node flag is held low. In those segments the command off-time varies from a few cycles to past the timeout, so both abandoned waits and watchdog expiry occur. Directed sequences also pin down the exact latencies and the blanking of stale flags.

// File: rtl/dtg_pkg.sv
package dtg_pkg;

    typedef enum logic [2:0] {
        SEQ_IDLE    = 3'd0,
        SEQ_HS_ON   = 3'd1,
        SEQ_WAIT_PH = 3'd2,
        SEQ_LS_ON   = 3'd3,
        SEQ_WAIT_LG = 3'd4
    } seq_state_e;

    typedef struct packed {
        seq_state_e st;
        logic       hs;
        logic       ls;
    } seq_regs_t;

endpackage

// File: rtl/dtg_sync.sv
module dtg_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [STAGES-1:0][WIDTH-1:0] stage_d;
    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    always_comb begin
        stage_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            stage_d[s] = stage_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/dtg_timer.sv
module dtg_timer #(
    parameter int LIMIT = 16,
    localparam int W    = $clog2(LIMIT + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart_i,
    output logic [W-1:0] count_o
);

    logic [W-1:0] cnt_d;
    logic [W-1:0] cnt_q;

    always_comb begin
        if (restart_i) begin
            cnt_d = '0;
        end else if (cnt_q == W'(LIMIT)) begin
            cnt_d = cnt_q;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign count_o = cnt_q;

    // R4: the wait timer saturates and never wraps past its limit
    a_r4_timer_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= W'(LIMIT));

endmodule

// File: rtl/dtg_fsm.sv
module dtg_fsm
    import dtg_pkg::*;
#(
    parameter int TMO   = 16,
    parameter int BLANK = 2,
    parameter int CW    = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable_i,
    input  logic          pwm_i,
    input  logic          force_ls_i,
    input  logic          ph_low_i,
    input  logic          lg_low_i,
    input  logic [CW-1:0] tmr_i,
    output logic          restart_o,
    output logic          hs_o,
    output logic          ls_o
);

    seq_regs_t cur_q;
    seq_regs_t nxt_d;
    logic      cmd;
    logic      settled;
    logic      expired;

    always_comb begin
        cmd     = pwm_i & ~force_ls_i;
        settled = (tmr_i >= CW'(BLANK));
        expired = (tmr_i == CW'(TMO - 1));
        nxt_d   = cur_q;

        unique case (cur_q.st)
            SEQ_IDLE: begin
                nxt_d.st = cmd ? SEQ_WAIT_LG : SEQ_WAIT_PH;
            end
            SEQ_HS_ON: begin
                if (!cmd) nxt_d.st = SEQ_WAIT_PH;
            end
            SEQ_WAIT_PH: begin
                if (cmd) begin
                    nxt_d.st = SEQ_WAIT_LG;
                end else if (settled && ph_low_i) begin
                    nxt_d.st = SEQ_LS_ON;
                end else if (expired) begin
                    nxt_d.st = SEQ_LS_ON;
                end
            end
            SEQ_LS_ON: begin
                if (cmd) nxt_d.st = SEQ_WAIT_LG;
            end
            SEQ_WAIT_LG: begin
                if (!cmd) begin
                    nxt_d.st = SEQ_WAIT_PH;
                end else if (settled && lg_low_i) begin
                    nxt_d.st = SEQ_HS_ON;
                end
            end
            default: nxt_d.st = SEQ_IDLE;
        endcase

        if (!enable_i) nxt_d.st = SEQ_IDLE;

        nxt_d.hs  = (nxt_d.st == SEQ_HS_ON);
        nxt_d.ls  = (nxt_d.st == SEQ_LS_ON);
        restart_o = (nxt_d.st != cur_q.st);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{st: SEQ_IDLE, hs: 1'b0, ls: 1'b0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign hs_o = cur_q.hs;
    assign ls_o = cur_q.ls;

    // R3/R4: the low side only rises on a settled phase confirmation or on timeout
    a_r3_ls_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ls_o) |-> ($past(ph_low_i) && $past(settled)) || $past(expired));

    // R5: the high side only rises on a settled low-gate confirmation
    a_r5_hs_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_o) |-> $past(lg_low_i) && $past(settled));

    // R6: a pending low-side turn-on never completes while the high side is requested
    a_r6_no_ls_under_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ls_o) |-> !$past(cmd));

    // R4: the phase wait never outlasts the watchdog
    a_r4_wait_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.st == SEQ_WAIT_PH) |-> (tmr_i < CW'(TMO)));

endmodule

// File: rtl/dtg_gate_sequencer.sv
module dtg_gate_sequencer #(
    parameter int WDOG_CYCLES = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable_i,
    input  logic pwm_i,
    input  logic force_ls_i,
    input  logic phase_low_i,
    input  logic ls_gate_low_i,
    output logic hs_gate_o,
    output logic ls_gate_o
);

    localparam int TW = $clog2(WDOG_CYCLES + 1);

    logic [1:0]    flags_s;
    logic [TW-1:0] tmr;
    logic          restart;

    dtg_sync #(
        .WIDTH  (2),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({ls_gate_low_i, phase_low_i}),
        .sync_o  (flags_s)
    );

    dtg_timer #(
        .LIMIT (WDOG_CYCLES)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (restart),
        .count_o   (tmr)
    );

    dtg_fsm #(
        .TMO   (WDOG_CYCLES),
        .BLANK (SYNC_STAGES),
        .CW    (TW)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable_i   (enable_i),
        .pwm_i      (pwm_i),
        .force_ls_i (force_ls_i),
        .ph_low_i   (flags_s[0]),
        .lg_low_i   (flags_s[1]),
        .tmr_i      (tmr),
        .restart_o  (restart),
        .hs_o       (hs_gate_o),
        .ls_o       (ls_gate_o)
    );

    // one cycle after reset release, so $past of the inputs is meaningful
    logic arm_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) arm_q <= 1'b0;
        else        arm_q <= 1'b1;
    end

    a_r2_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_gate_o && ls_gate_o));

    a_r2_gap_hs_to_ls: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ls_gate_o) |-> !$past(hs_gate_o));

    a_r2_gap_ls_to_hs: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_gate_o) |-> !$past(ls_gate_o));

    a_r7_disable_off: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_q && !$past(enable_i)) |-> (!hs_gate_o && !ls_gate_o));

    a_r8_force_blocks_hs: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_q && $past(force_ls_i)) |-> !hs_gate_o);

endmodule

// File: tb/dtg_gate_sequencer_bench.sv
`timescale 1ns/1ps
module dtg_gate_sequencer_bench;

    localparam int WDOG = 16;
    localparam int SYNC = 2;

    localparam int M_IDLE = 0, M_HS = 1, M_WPH = 2, M_LS = 3, M_WLG = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0, pwm = 1'b0, frc = 1'b0, ph_lo = 1'b0, lg_lo = 1'b1;
    logic hs, ls;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    int    m_st = M_IDLE;
    int    m_cnt = 0;
    bit    m_p1 = 0, m_p2 = 0, m_g1 = 0, m_g2 = 0;
    bit    m_hs = 0, m_ls = 0;
    string m_tag = "R1";

    always #2.5 clk = ~clk;

    dtg_gate_sequencer #(
        .WDOG_CYCLES (WDOG),
        .SYNC_STAGES (SYNC)
    ) u_dtg_gate_sequencer (
        .clk           (clk),
        .rst_n         (rst_n),
        .enable_i      (en),
        .pwm_i         (pwm),
        .force_ls_i    (frc),
        .phase_low_i   (ph_lo),
        .ls_gate_low_i (lg_lo),
        .hs_gate_o     (hs),
        .ls_gate_o     (ls)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // reference behaviour built from the requirements, advanced once per rising edge
    task automatic model_step();
        bit cmd;
        int ns;
        if (!rst_n) begin
            m_st = M_IDLE; m_cnt = 0; m_p1 = 0; m_p2 = 0; m_g1 = 0; m_g2 = 0;
            m_hs = 0; m_ls = 0; m_tag = "R1";
            return;
        end
        cmd = pwm && !frc;
        ns  = m_st;
        case (m_st)
            M_IDLE: begin ns = cmd ? M_WLG : M_WPH; m_tag = "R10"; end
            M_HS:   begin ns = cmd ? M_HS : M_WPH; m_tag = frc ? "R8" : "R9"; end
            M_WPH: begin
                if (cmd) begin ns = M_WLG; m_tag = "R6"; end
                else if (m_cnt >= SYNC && m_p2) begin ns = M_LS; m_tag = "R3"; end
                else if (m_cnt == WDOG - 1) begin ns = M_LS; m_tag = "R4"; end
                else m_tag = "R3";
            end
            M_LS:   begin ns = cmd ? M_WLG : M_LS; m_tag = frc ? "R8" : "R9"; end
            default: begin
                if (!cmd) begin ns = M_WPH; m_tag = "R6"; end
                else if (m_cnt >= SYNC && m_g2) begin ns = M_HS; m_tag = "R5"; end
                else m_tag = "R5";
            end
        endcase
        if (!en) begin ns = M_IDLE; m_tag = "R7"; end
        if (ns != m_st) m_cnt = 0;
        else if (m_cnt < WDOG) m_cnt++;
        m_st = ns;
        m_p2 = m_p1; m_p1 = ph_lo;
        m_g2 = m_g1; m_g1 = lg_lo;
        m_hs = (ns == M_HS);
        m_ls = (ns == M_LS);
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        chk(hs == m_hs, m_tag, "hs_gate_o", int'(hs), int'(m_hs));
        chk(ls == m_ls, m_tag, "ls_gate_o", int'(ls), int'(m_ls));
        chk(!(hs && ls), "R2", "overlap", int'(hs && ls), 0);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        int unsigned seed;
        int n;
        bit seen;
        seed = $urandom(32'd20251);

        // R1: reset state
        repeat (3) tick();
        chk(hs == 1'b0 && ls == 1'b0, "R1", "gates in reset", int'({hs, ls}), 0);
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) begin
            pwm = i[0];
            tick();
            chk(hs == 1'b0 && ls == 1'b0, "R1", "gates while disabled", int'({hs, ls}), 0);
        end

        // R10/R5: enable with command high, low-gate flag already settled
        en = 1'b1; pwm = 1'b1; lg_lo = 1'b1; ph_lo = 1'b0;
        repeat (3) tick();
        chk(hs == 1'b0, "R10", "hs before 4th edge", int'(hs), 0);
        tick();
        chk(hs == 1'b1, "R10", "hs at 4th edge", int'(hs), 1);

        // R4: switching node never drops, watchdog expiry
        pwm = 1'b0; ph_lo = 1'b0;
        n = 0;
        while (!ls && n < 40) begin tick(); n++; end
        chk(n - 1 == WDOG, "R4", "cycles hs-off to ls-on", n - 1, WDOG);
        for (int i = 0; i < 5; i++) tick();
        chk(ls == 1'b1, "R9", "ls held under low command", int'(ls), 1);

        // R5: low-gate flag late, then confirmed
        pwm = 1'b1; lg_lo = 1'b0;
        seen = 0;
        for (int i = 0; i < 6; i++) begin tick(); if (hs) seen = 1; end
        chk(!seen, "R5", "hs without low-gate flag", int'(seen), 0);
        lg_lo = 1'b1;
        n = 0;
        while (!hs && n < 20) begin tick(); n++; end
        chk(n == 3, "R5", "edges from flag to hs", n, 3);

        // R3: switching-node flag arrives during the wait
        pwm = 1'b0; ph_lo = 1'b0;
        for (int i = 0; i < 5; i++) tick();
        chk(ls == 1'b0, "R3", "ls before phase flag", int'(ls), 0);
        ph_lo = 1'b1;
        n = 0;
        while (!ls && n < 20) begin tick(); n++; end
        chk(n == 3, "R3", "edges from flag to ls", n, 3);

        // R6: command returns while the low-side turn-on is pending
        pwm = 1'b1; ph_lo = 1'b0;
        for (int i = 0; i < 6; i++) tick();
        chk(hs == 1'b1, "R6", "hs before abandon test", int'(hs), 1);
        pwm = 1'b0;
        for (int i = 0; i < 4; i++) tick();
        pwm = 1'b1;
        seen = 0;
        for (int i = 0; i < 10; i++) begin tick(); if (ls) seen = 1; end
        chk(!seen, "R6", "ls after abandoned wait", int'(seen), 0);
        chk(hs == 1'b1, "R6", "hs after low-gate confirm", int'(hs), 1);

        // R8: forced low side
        frc = 1'b1; ph_lo = 1'b1;
        tick();
        chk(hs == 1'b0, "R8", "hs after force", int'(hs), 0);
        seen = 0;
        for (int i = 0; i < 9; i++) begin tick(); if (hs) seen = 1; end
        chk(!seen, "R8", "hs while forced", int'(seen), 0);
        chk(ls == 1'b1, "R8", "ls while forced", int'(ls), 1);

        // R7: disable from low-side on
        en = 1'b0;
        tick();
        chk(hs == 1'b0 && ls == 1'b0, "R7", "gates after disable", int'({hs, ls}), 0);
        for (int i = 0; i < 5; i++) begin
            pwm = i[0]; frc = 1'b0;
            tick();
            chk(hs == 1'b0 && ls == 1'b0, "R7", "gates held off", int'({hs, ls}), 0);
        end
        en = 1'b1;

        // random segments with a simple power-stage plant
        for (int seg = 0; seg < 60; seg++) begin
            int len;
            int duty;
            bit neg;
            bit fseg;
            len  = 30 + int'($urandom % 50);
            duty = 2 + int'($urandom % 20);
            neg  = ($urandom % 3) == 0;
            fseg = ($urandom % 8) == 0;
            for (int c = 0; c < len; c++) begin
                pwm   = ((c % 24) < duty);
                frc   = fseg && (c > len / 2);
                en    = ($urandom % 40) != 0;
                ph_lo = neg ? 1'b0 : (hs ? 1'b0 : ((($urandom % 4) != 0) ? 1'b1 : ph_lo));
                lg_lo = ls ? 1'b0 : ((($urandom % 3) != 0) ? 1'b1 : lg_lo);
                tick();
            end
        end

        done = 1;
        summary();
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R1 watchdog expired actual=hung expected=finished");
            summary();
            $finish;
        end
    end

endmodule